// File: doc/BRIEF.md
# Transmit Framing Sequencer

This block sits between a host bus and a serial modulator on the transmit side of a packet radio modem. The host writes 47 six-bit data symbols into an input buffer. Writing the last symbol marks the buffer ready and asks an external parity generator for 16 parity symbols over a start/done handshake. At each block boundary the block checks whether a ready set with its parity is waiting. If one is, that set is moved into an output buffer, where it stays fixed for the whole block. If none is, the output buffer keeps its contents and the same block goes out again.

The output buffer is sent one bit per bit strobe. A block carries the 47 data symbols, then the 16 parity symbols, each sent most significant bit first. Data bits are XORed with a PRBS from an LFSR that is reseeded at every block start. After every 9 symbols an unscrambled continuity bit is inserted. Before the first block after leaving powersave, and before the first block after the continuity control rises from 0 to 1, an unscrambled preamble is sent: an alternating dotting run and then a block sync word.

The controller has six states. IDLE is powersave, LOAD is the boundary decision, DOT is the dotting run, SYNC is the sync word, DATA is the symbol bits and CIB is the continuity bit. Transitions: any state goes to IDLE while powersave is high. IDLE goes to LOAD when powersave is low. LOAD goes to DOT if a preamble is owed, and to DATA otherwise. DOT goes to SYNC after the last dotting bit. SYNC goes to DATA after the last sync bit. DATA goes to CIB after the ninth symbol of a group, and to LOAD after a final symbol that does not close a group. CIB goes to DATA, or to LOAD after the final symbol.

Top module: `tx_frame_seq`

## Requirements
- R1: A write with `wr_en` high stores `wr_data` at symbol index `wr_addr` when that index is 0 to 46. A write to index 46 marks the input buffer ready, and `par_start` is high for one cycle in the cycle that follows it.
- R2: A `par_done` pulse captures `par_syms`, with parity symbol j at bits [6j+5:6j]. A block sends data symbols 0..46 and then parity symbols 0..15, each most significant bit first.
- R3: In LOAD, a ready buffer whose parity has been captured is moved into the output buffer and ready is cleared. The output contents and the continuity bit (sampled from `ci_in` in LOAD) do not change until the next LOAD.
- R4: If nothing is ready in LOAD, the previous output contents are sent again. Writes to indices 0..45 alone do not make the buffer ready. Rewriting only index 46 sends the current input buffer contents.
- R5: Each data bit is XORed with the LFSR's most significant bit. The LFSR is loaded with `PRBS_SEED` in LOAD. After each data bit it shifts left, taking in as its new bit 0 the XOR of (state AND `PRBS_TAPS`).
- R6: After every 9th symbol of a block, one continuity bit equal to the sampled `ci_in` is sent, unscrambled.
- R7: A preamble of 38 bits alternating 1,0 (starting with 1), then `SYNC_WORD` most significant bit first, is sent unscrambled before the first block after powersave and before the first block after `ci_in` rises.
- R8: While `ps_tx` is high, `tx_on` and `tx_bit` go to 0 in the cycle after it is seen, and sending is cut at once. After reset the outputs are 0.
- R9: `tx_empty` is high for exactly one cycle, in the cycle after the strobe that takes the final bit of a block.
- R10: `tx_bit` changes only on a cycle with `bit_stb` high; each strobe takes one bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Symbol write strobe |
| wr_addr | input | ADDR_W | Symbol index |
| wr_data | input | W | Symbol value |
| par_start | output | 1 | Request to the parity generator |
| par_done | input | 1 | Parity generator finished |
| par_syms | input | N_PAR*W | Parity symbols from the generator |
| stage_syms | output | N_DATA*W | Input buffer contents for the parity generator |
| ci_in | input | 1 | Continuity control |
| ps_tx | input | 1 | Transmit powersave |
| bit_stb | input | 1 | Bit-period strobe |
| tx_bit | output | 1 | Serial bit presented to the modulator |
| tx_on | output | 1 | Transmitter active |
| tx_empty | output | 1 | Output buffer sent |

## Verification
The bench builds the block with its default values: 47 data and 16 parity symbols of 6 bits, a continuity bit every 9 symbols, 38 dotting bits, the 22-bit sync word 22'h2D9C63, and a 9-bit LFSR with taps 9'h110 seeded with 9'h1FF. Since 63 is a multiple of 9, every block ends in CIB, so the path from CIB to LOAD is exercised. The full-length PRBS pattern spans hundreds of bits, so an error in the reseed or in the feedback taps shows up at once. The bench also checks resend after a partial reload, rewriting only index 46, a ci_in rise, and a powersave cut in the middle of a block.

// File: rtl/tfs_pkg.sv
package tfs_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD,
        ST_DOT,
        ST_SYNC,
        ST_DATA,
        ST_CIB
    } tfs_state_e;
endpackage

// File: rtl/tfs_lfsr.sv
module tfs_lfsr #(
    parameter int               LW   = 9,
    parameter logic [LW-1:0]    TAPS = 9'h110,
    parameter logic [LW-1:0]    SEED = 9'h1FF
) (
    input  logic clk,
    input  logic rst_n,
    input  logic seed_ld,
    input  logic adv,
    output logic out_bit
);
    logic [LW-1:0] state;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= SEED;
        else if (seed_ld)
            state <= SEED;
        else if (adv)
            state <= {state[LW-2:0], ^(state & TAPS)};
    end

    assign out_bit = state[LW-1];

    // R5: a live scrambler never reaches the all-zero lock-up state
    always_ff @(posedge clk) begin
        if (rst_n)
            p_prbs_live_r5: assert (state != '0) else $error("prbs locked at zero");
    end
endmodule

// File: rtl/tfs_stage.sv
module tfs_stage #(
    parameter int W      = 6,
    parameter int N_DATA = 47,
    parameter int N_PAR  = 16,
    parameter int AW     = 6
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [AW-1:0]         wr_addr,
    input  logic [W-1:0]          wr_data,
    input  logic                  par_done,
    input  logic [N_PAR*W-1:0]    par_in,
    input  logic                  take,
    output logic [N_DATA*W-1:0]   stage_syms,
    output logic [N_PAR*W-1:0]    par_hold,
    output logic                  staged_ok,
    output logic                  par_start
);
    localparam logic [AW-1:0] LAST_IDX = AW'(N_DATA - 1);

    logic [W-1:0] mem [N_DATA];
    logic         ready, par_ok;
    logic         wr_hit, wr_last;

    assign wr_hit  = wr_en && (int'(wr_addr) < N_DATA);
    assign wr_last = wr_en && (wr_addr == LAST_IDX);

    always_ff @(posedge clk) begin
        if (wr_hit)
            mem[wr_addr] <= wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ready     <= 1'b0;
            par_ok    <= 1'b0;
            par_start <= 1'b0;
            par_hold  <= '0;
        end else begin
            par_start <= wr_last;
            if (wr_last)
                ready <= 1'b1;
            else if (take)
                ready <= 1'b0;
            if (wr_last)
                par_ok <= 1'b0;
            else if (par_done) begin
                par_ok   <= 1'b1;
                par_hold <= par_in;
            end
        end
    end

    assign staged_ok = ready && par_ok;

    for (genvar i = 0; i < N_DATA; i++) begin : g_flat
        assign stage_syms[i*W +: W] = mem[i];
    end

    // R3: the sequencer only takes a buffer that is complete
    p_take_ready_r3: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> staged_ok);
    // R1: a parity request always follows a write
    p_start_after_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
        par_start |-> $past(wr_en));
endmodule

// File: rtl/tfs_serial.sv
module tfs_serial
    import tfs_pkg::*;
#(
    parameter int                  W         = 6,
    parameter int                  N_DATA    = 47,
    parameter int                  N_PAR     = 16,
    parameter int                  CI_EVERY  = 9,
    parameter int                  DOT_LEN   = 38,
    parameter int                  SYNC_LEN  = 22,
    parameter logic [SYNC_LEN-1:0] SYNC_WORD = 22'h2D9C63,
    parameter int                  PRBS_W    = 9,
    parameter logic [PRBS_W-1:0]   PRBS_TAPS = 9'h110,
    parameter logic [PRBS_W-1:0]   PRBS_SEED = 9'h1FF
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [N_DATA*W-1:0]   stage_syms,
    input  logic [N_PAR*W-1:0]    par_syms,
    input  logic                  staged_ok,
    input  logic                  ci_in,
    input  logic                  ps_tx,
    input  logic                  bit_stb,
    output logic                  take,
    output logic                  tx_bit,
    output logic                  tx_on,
    output logic                  tx_empty
);
    localparam int N_SYM   = N_DATA + N_PAR;
    localparam int SI_W    = $clog2(N_SYM);
    localparam int BI_W    = $clog2(W);
    localparam int GRP_W   = $clog2(CI_EVERY + 1);
    localparam int PRE_MAX = (DOT_LEN > SYNC_LEN) ? DOT_LEN : SYNC_LEN;
    localparam int PRE_W   = $clog2(PRE_MAX + 1);
    localparam logic [SI_W-1:0]  SI_LAST   = SI_W'(N_SYM - 1);
    localparam logic [BI_W-1:0]  BI_TOP    = BI_W'(W - 1);
    localparam logic [GRP_W-1:0] GRP_LAST  = GRP_W'(CI_EVERY - 1);
    localparam logic [PRE_W-1:0] DOT_LAST  = PRE_W'(DOT_LEN - 1);
    localparam logic [PRE_W-1:0] SYNC_LAST = PRE_W'(SYNC_LEN - 1);

    tfs_state_e st, st_nx;

    logic [W-1:0]        blk [N_SYM];
    logic                blk_ci, ci_q, need_pre, empty_q;
    logic [PRE_W-1:0]    cnt;
    logic [SYNC_LEN-1:0] sync_sr;
    logic [SI_W-1:0]     si;
    logic [BI_W-1:0]     bi;
    logic [GRP_W-1:0]    grp;
    logic                prbs;
    logic                stb_ok, dot_end, sync_end, sym_end, grp_full, last_sym, fin;

    assign stb_ok   = bit_stb && !ps_tx;
    assign dot_end  = stb_ok && (st == ST_DOT)  && (cnt == DOT_LAST);
    assign sync_end = stb_ok && (st == ST_SYNC) && (cnt == SYNC_LAST);
    assign sym_end  = stb_ok && (st == ST_DATA) && (bi == '0);
    assign grp_full = (grp == GRP_LAST);
    assign last_sym = (si == SI_LAST);
    assign fin      = (sym_end && !grp_full && last_sym)
                   || (stb_ok && (st == ST_CIB) && last_sym);

    tfs_lfsr #(.LW(PRBS_W), .TAPS(PRBS_TAPS), .SEED(PRBS_SEED)) u_prbs (
        .clk     (clk),
        .rst_n   (rst_n),
        .seed_ld (st == ST_LOAD),
        .adv     (stb_ok && (st == ST_DATA)),
        .out_bit (prbs)
    );

    // next state
    always_comb begin
        st_nx = st;
        if (ps_tx)
            st_nx = ST_IDLE;
        else begin
            unique case (st)
                ST_IDLE: st_nx = ST_LOAD;
                ST_LOAD: st_nx = need_pre ? ST_DOT : ST_DATA;
                ST_DOT:  if (dot_end)  st_nx = ST_SYNC;
                ST_SYNC: if (sync_end) st_nx = ST_DATA;
                ST_DATA: if (sym_end)
                             st_nx = grp_full ? ST_CIB : (last_sym ? ST_LOAD : ST_DATA);
                ST_CIB:  if (stb_ok)   st_nx = last_sym ? ST_LOAD : ST_DATA;
                default: st_nx = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nx;
    end

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < N_SYM; i++) blk[i] <= '0;
            blk_ci   <= 1'b0;
            ci_q     <= 1'b0;
            need_pre <= 1'b1;
            empty_q  <= 1'b0;
            cnt      <= '0;
            sync_sr  <= '0;
            si       <= '0;
            bi       <= '0;
            grp      <= '0;
        end else begin
            ci_q    <= ci_in;
            empty_q <= fin;
            if (ps_tx || (ci_in && !ci_q))
                need_pre <= 1'b1;
            else if (st == ST_LOAD)
                need_pre <= 1'b0;
            unique case (st)
                ST_LOAD: begin
                    if (staged_ok) begin
                        for (int i = 0; i < N_DATA; i++) blk[i] <= stage_syms[i*W +: W];
                        for (int j = 0; j < N_PAR; j++)  blk[N_DATA+j] <= par_syms[j*W +: W];
                    end
                    blk_ci <= ci_in;
                    cnt    <= '0;
                    si     <= '0;
                    bi     <= BI_TOP;
                    grp    <= '0;
                end
                ST_DOT: if (stb_ok) begin
                    if (dot_end) begin
                        cnt     <= '0;
                        sync_sr <= SYNC_WORD;
                    end else
                        cnt <= cnt + 1'b1;
                end
                ST_SYNC: if (stb_ok) begin
                    sync_sr <= {sync_sr[SYNC_LEN-2:0], 1'b0};
                    cnt     <= cnt + 1'b1;
                end
                ST_DATA: if (stb_ok) begin
                    if (bi == '0) begin
                        bi <= BI_TOP;
                        if (grp_full)
                            grp <= '0;
                        else begin
                            grp <= grp + 1'b1;
                            if (!last_sym) si <= si + 1'b1;
                        end
                    end else
                        bi <= bi - 1'b1;
                end
                ST_CIB: if (stb_ok && !last_sym) si <= si + 1'b1;
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        tx_on    = (st != ST_IDLE);
        take     = (st == ST_LOAD) && staged_ok;
        tx_empty = empty_q;
        unique case (st)
            ST_DOT:  tx_bit = ~cnt[0];
            ST_SYNC: tx_bit = sync_sr[SYNC_LEN-1];
            ST_DATA: tx_bit = blk[si][bi] ^ prbs;
            ST_CIB:  tx_bit = blk_ci;
            default: tx_bit = 1'b0;
        endcase
    end

    p_ps_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ps_tx |=> !tx_on);
    p_empty_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        tx_empty |=> !tx_empty);
    p_empty_at_boundary_r9: assert property (@(posedge clk) disable iff (!rst_n)
        tx_empty |-> (st == ST_LOAD) || ps_tx || $past(ps_tx));
    p_ci_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st != ST_LOAD) |=> $stable(blk_ci));
    p_bit_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ((st == ST_DATA) && !bit_stb && !ps_tx) |=> $stable(tx_bit));
endmodule

// File: rtl/tx_frame_seq.sv
module tx_frame_seq #(
    parameter int                  W         = 6,
    parameter int                  N_DATA    = 47,
    parameter int                  N_PAR     = 16,
    parameter int                  CI_EVERY  = 9,
    parameter int                  DOT_LEN   = 38,
    parameter int                  SYNC_LEN  = 22,
    parameter logic [SYNC_LEN-1:0] SYNC_WORD = 22'h2D9C63,
    parameter int                  PRBS_W    = 9,
    parameter logic [PRBS_W-1:0]   PRBS_TAPS = 9'h110,
    parameter logic [PRBS_W-1:0]   PRBS_SEED = 9'h1FF,
    parameter int                  ADDR_W    = $clog2(N_DATA)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    wr_addr,
    input  logic [W-1:0]         wr_data,
    output logic                 par_start,
    input  logic                 par_done,
    input  logic [N_PAR*W-1:0]   par_syms,
    output logic [N_DATA*W-1:0]  stage_syms,
    input  logic                 ci_in,
    input  logic                 ps_tx,
    input  logic                 bit_stb,
    output logic                 tx_bit,
    output logic                 tx_on,
    output logic                 tx_empty
);
    logic [N_PAR*W-1:0] par_hold;
    logic               staged_ok, take;

    tfs_stage #(.W(W), .N_DATA(N_DATA), .N_PAR(N_PAR), .AW(ADDR_W)) u_stage (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .par_done   (par_done),
        .par_in     (par_syms),
        .take       (take),
        .stage_syms (stage_syms),
        .par_hold   (par_hold),
        .staged_ok  (staged_ok),
        .par_start  (par_start)
    );

    tfs_serial #(
        .W(W), .N_DATA(N_DATA), .N_PAR(N_PAR), .CI_EVERY(CI_EVERY),
        .DOT_LEN(DOT_LEN), .SYNC_LEN(SYNC_LEN), .SYNC_WORD(SYNC_WORD),
        .PRBS_W(PRBS_W), .PRBS_TAPS(PRBS_TAPS), .PRBS_SEED(PRBS_SEED)
    ) u_serial (
        .clk        (clk),
        .rst_n      (rst_n),
        .stage_syms (stage_syms),
        .par_syms   (par_hold),
        .staged_ok  (staged_ok),
        .ci_in      (ci_in),
        .ps_tx      (ps_tx),
        .bit_stb    (bit_stb),
        .take       (take),
        .tx_bit     (tx_bit),
        .tx_on      (tx_on),
        .tx_empty   (tx_empty)
    );
endmodule

// File: tb/sim_tx_frame_seq.sv
`timescale 1ns/1ps
module sim_tx_frame_seq;
    localparam int               W    = 6;
    localparam int               ND   = 47;
    localparam int               NP   = 16;
    localparam int               NS   = ND + NP;
    localparam int               CIE  = 9;
    localparam int               DOT  = 38;
    localparam int               SL   = 22;
    localparam logic [SL-1:0]    SW   = 22'h2D9C63;
    localparam logic [8:0]       TAPS = 9'h110;
    localparam logic [8:0]       SEED = 9'h1FF;

    // row = {action[1:0], ci, base[5:0]}; action 0 none, 1 full load, 2 index 46 only, 3 indices 0..45 only
    localparam logic [8:0] ROWS [6] = '{
        {2'd1, 1'b1, 6'd17},
        {2'd0, 1'b0, 6'd0},
        {2'd1, 1'b1, 6'd40},
        {2'd3, 1'b1, 6'd50},
        {2'd2, 1'b1, 6'd0},
        {2'd0, 1'b1, 6'd0}
    };

    logic clk = 0, rst_n = 0, wr_en = 0, par_done = 0, ci_in = 0, ps_tx = 1, bit_stb = 0;
    logic [5:0]      wr_addr = '0, wr_data = '0;
    logic [NP*W-1:0] par_syms = '0;
    logic [ND*W-1:0] stage_syms;
    logic            par_start, tx_bit, tx_on, tx_empty;

    tx_frame_seq #(
        .W(W), .N_DATA(ND), .N_PAR(NP), .CI_EVERY(CIE), .DOT_LEN(DOT),
        .SYNC_LEN(SL), .SYNC_WORD(SW), .PRBS_W(9), .PRBS_TAPS(TAPS), .PRBS_SEED(SEED)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .par_start(par_start), .par_done(par_done), .par_syms(par_syms),
        .stage_syms(stage_syms), .ci_in(ci_in), .ps_tx(ps_tx), .bit_stb(bit_stb),
        .tx_bit(tx_bit), .tx_on(tx_on), .tx_empty(tx_empty)
    );

    always #2 clk = ~clk;

    int errors = 0, checks = 0;
    bit done = 0;

    logic [5:0] stg [ND];
    logic [5:0] spar [NP];
    logic [5:0] oblk [NS];
    bit st_ready = 0, ci_lvl = 0, need_pre_m = 1;
    bit expv [512];
    int nexp;

    task automatic check(input bit ok, input string what);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s", what);
        end
    endtask

    task automatic set_ci(input bit v);
        if (v && !ci_lvl) need_pre_m = 1;
        ci_lvl = v;
        ci_in  = v;
    endtask

    // R1 R4: host loads; mode 1 all, 2 index 46 only, 3 indices 0..45 only
    task automatic load(input int base, input int mode);
        for (int i = 0; i < ND; i++) begin
            if (mode == 1 || (mode == 3 && i < ND-1) || (mode == 2 && i == ND-1)) begin
                @(negedge clk);
                wr_en   = 1;
                wr_addr = 6'(i);
                wr_data = (mode == 2) ? stg[i] : 6'(base + 5*i + 3);
                stg[i]  = wr_data;
            end
        end
        @(negedge clk);
        wr_en = 0;
        if (mode != 3) begin
            check(par_start === 1'b1, $sformatf("R1 parity request: got %0b expected 1", par_start));
            repeat (3) @(negedge clk);
            for (int j = 0; j < NP; j++) begin
                spar[j] = 6'(base*3 + 7*j + 1);
                par_syms[j*W +: W] = spar[j];
            end
            par_done = 1;
            @(negedge clk);
            par_done = 0;
            st_ready = 1;
        end
    endtask

    // model of the boundary decision (R3 R4) and the stream (R2 R5 R6 R7)
    task automatic begin_block();
        logic [8:0] lf;
        bit pre, cib;
        if (st_ready) begin
            for (int i = 0; i < ND; i++) oblk[i] = stg[i];
            for (int j = 0; j < NP; j++) oblk[ND+j] = spar[j];
            st_ready = 0;
        end
        pre = need_pre_m;
        need_pre_m = 0;
        cib = ci_lvl;
        nexp = 0;
        if (pre) begin
            for (int i = 0; i < DOT; i++) expv[nexp++] = (i % 2 == 0);
            for (int i = 0; i < SL; i++)  expv[nexp++] = SW[SL-1-i];
        end
        lf = SEED;
        for (int s = 0; s < NS; s++) begin
            for (int b = W-1; b >= 0; b--) begin
                expv[nexp++] = oblk[s][b] ^ lf[8];
                lf = {lf[7:0], ^(lf & TAPS)};
            end
            if ((s + 1) % CIE == 0) expv[nexp++] = cib;
        end
    endtask

    task automatic stb_bit(output bit b, output bit hold_ok, output bit emp);
        bit b0;
        @(negedge clk);
        b0 = tx_bit;
        @(negedge clk);
        b = tx_bit;
        hold_ok = (b0 == b);
        bit_stb = 1;
        @(negedge clk);
        bit_stb = 0;
        emp = tx_empty;
    endtask

    task automatic run_block(input int id, input int row, input int abort_at);
        bit b, h, e;
        int bad_at = -1, emp_bad = -1;
        bit bad_got = 0;
        begin_block();
        for (int i = 0; i < nexp; i++) begin
            if (abort_at >= 0 && i == abort_at) begin
                ps_tx = 1;
                need_pre_m = 1;
                @(negedge clk);
                check(tx_on === 1'b0 && tx_bit === 1'b0,
                      $sformatf("R8 powersave cut: got on=%0b bit=%0b expected 0 0", tx_on, tx_bit));
                return;
            end
            if (row >= 0 && i == 100) begin
                if (ROWS[row][8:7] != 2'd0) load(int'(ROWS[row][5:0]), int'(ROWS[row][8:7]));
                set_ci(ROWS[row][6]);
            end
            stb_bit(b, h, e);
            if (bad_at < 0 && (b !== expv[i] || !h)) begin
                bad_at = i;
                bad_got = b;
            end
            if (emp_bad < 0 && (e != (i == nexp - 1))) emp_bad = i;
        end
        check(bad_at < 0, $sformatf("R2/R5/R6/R7/R10 block %0d bit %0d: got %0b expected %0b",
                                     id, bad_at, bad_got, (bad_at < 0) ? 1'b0 : expv[bad_at]));
        check(emp_bad < 0, $sformatf("R9 block %0d empty pulse at bit %0d: got %0b expected %0b",
                                      id, emp_bad, (emp_bad < 0) ? 1'b0 : ~(emp_bad == nexp-1),
                                      (emp_bad < 0) ? 1'b0 : (emp_bad == nexp-1)));
    endtask

    initial begin
        for (int j = 0; j < NS; j++) oblk[j] = '0;
        for (int i = 0; i < ND; i++) stg[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check(tx_on === 0 && tx_bit === 0 && tx_empty === 0 && par_start === 0,
              $sformatf("R8 reset: got on=%0b bit=%0b empty=%0b start=%0b expected 0 0 0 0",
                        tx_on, tx_bit, tx_empty, par_start));
        load(5, 1);
        set_ci(1);
        @(negedge clk);
        ps_tx = 0;
        repeat (2) @(negedge clk);
        for (int r = 0; r < 6; r++) run_block(r, r, -1);
        run_block(6, -1, 50);
        @(negedge clk);
        ps_tx = 0;
        repeat (2) @(negedge clk);
        run_block(7, -1, -1);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got running expected finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule